// File: doc/BRIEF.md
# I2C Master Baud Generator with Clock Arbitration

This block sets the pace of an I2C master. It is a down-counter that measures each half-period of SCL and each SDA setup or hold interval. The sequencer that drives START, STOP and the data bits loads it with a divisor and waits for its timeout pulse. The count moves by one on each of two phase enables that arrive inside every instruction cycle, so each instruction cycle gives two steps. When the count runs out, the block raises the timeout for one clock and starts the next period from the divisor.

Clock arbitration is built into the expiry. The master may have released SCL while another device still pulls the line low. If that is the case when the count runs out, the counter stops at zero and waits. It signals nothing and does not reload. On the first step at which the synchronized SCL level reads high, it reloads and signals the timeout, so a slow device stretches the half-period.

The sequencer steers the block with three commands. Reload restarts the count at once from the divisor. Suspend freezes the count where it is. Run resumes counting without a reload. The raw SCL pin level passes through a two-flop synchronizer before it is used.

Top module: `i2c_baud_gen`

## Requirements
- R1: A synchronous reset sets the count to 0, clears the timeout and leaves the block suspended. After reset, phase enables change neither the count nor the timeout until a reload or a run command arrives.
- R2: A reload command sets the count, one clock later, to the effective divisor and leaves the block running.
- R3: The count drops by one only on a clock where phase_a_en or phase_b_en is high. On any other clock the count holds and no timeout occurs.
- R4: A step taken at count 1 (or 0) is an expiry. If there is no hold-off, an expiry gives timeout_o = 1 on the next clock, and the count is reloaded with the effective divisor. A period therefore lasts exactly that many steps.
- R5: A divisor of 0 acts as 1, so every step is an expiry.
- R6: An expiry while scl_released_i is 1 and the synchronized SCL is low gives count 0 and no timeout. The block then holds at 0 with no timeout for as long as the synchronized SCL stays low.
- R7: During hold-off, the first step that sees the synchronized SCL high reloads the effective divisor and gives a timeout pulse.
- R8: Suspend freezes the count even while steps arrive. Run resumes counting from the frozen value, without a reload.
- R9: scl_pin_i reaches the decision logic through exactly two flops. During hold-off with a step on every clock, a rise on the pin gives its timeout on the third clock edge after the rise, and not earlier.
- R10: Commands have the priority reload over suspend over run. A clock that carries a command takes no step. A timeout lasts one clock unless the next step is also an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a_en | input | 1 | First phase enable of the instruction cycle; a step |
| phase_b_en | input | 1 | Second phase enable of the instruction cycle; a step |
| divisor | input | DIV_W | Reload value (default 7 bits); 0 acts as 1 |
| run_i | input | 1 | Resume counting without reload |
| reload_i | input | 1 | Reload count from divisor and run |
| suspend_i | input | 1 | Freeze the count |
| scl_released_i | input | 1 | Master currently releases SCL (line may float high) |
| scl_pin_i | input | 1 | Raw SCL line level, asynchronous |
| timeout_o | output | 1 | One-clock pulse at end of a baud period |
| count_o | output | DIV_W | Current count |

## Verification
The bench sweeps divisors 0 through 9, plus the largest divisor, against step spacings of one, two and three clocks, with steps on both phases. It checks the count on every clock against arithmetic, which exposes an off-by-one period, a missed phase enable, or a zero divisor that stalls the counter. The hold-off case keeps SCL low past expiry. A design that ignored the line would fire a timeout early, and one that reloaded during hold-off would count on while the clock is stretched. The release of the line is then timed edge by edge, so a synchronizer with one flop too few or too many shows up as an early or late timeout. Command collisions and suspend during steps check that reload wins, that run does not reload, and that a frozen count stays frozen.

// File: rtl/i2c_bg_pkg.sv
package i2c_bg_pkg;

    // Command chosen for the current clock after priority resolution.
    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_RUN     = 2'd1,
        CMD_SUSPEND = 2'd2,
        CMD_RELOAD  = 2'd3
    } bg_cmd_e;

endpackage

// File: rtl/i2c_bg_sync.sv
module i2c_bg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    assign sh_d[0] = d_i;

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            assign sh_d[i] = sh_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sh_q <= {STAGES{RST_VAL}};
        else     sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_bg_div_norm.sv
module i2c_bg_div_norm #(
    parameter int DIV_W = 7
) (
    input  logic [DIV_W-1:0] divisor_i,
    output logic [DIV_W-1:0] reload_o
);
    localparam logic [DIV_W-1:0] MIN_PERIOD = DIV_W'(1);

    always_comb begin
        reload_o = divisor_i;
        if (divisor_i == '0) reload_o = MIN_PERIOD;
    end
endmodule

// File: rtl/i2c_bg_cmd_dec.sv
module i2c_bg_cmd_dec
    import i2c_bg_pkg::*;
(
    input  logic    run_i,
    input  logic    reload_i,
    input  logic    suspend_i,
    output bg_cmd_e cmd_o
);
    always_comb begin
        cmd_o = CMD_NONE;
        if (reload_i)       cmd_o = CMD_RELOAD;
        else if (suspend_i) cmd_o = CMD_SUSPEND;
        else if (run_i)     cmd_o = CMD_RUN;
    end
endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen
    import i2c_bg_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_a_en,
    input  logic             phase_b_en,
    input  logic [DIV_W-1:0] divisor,
    input  logic             run_i,
    input  logic             reload_i,
    input  logic             suspend_i,
    input  logic             scl_released_i,
    input  logic             scl_pin_i,
    output logic             timeout_o,
    output logic [DIV_W-1:0] count_o
);
    localparam logic [DIV_W-1:0] LAST_STEP = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] count;
        logic             susp;
        logic             hold;
        logic             timeout;
    } bg_state_t;

    localparam bg_state_t RESET_STATE = '{count: '0, susp: 1'b1, hold: 1'b0, timeout: 1'b0};

    bg_state_t        st_d;
    bg_state_t        st_q;
    logic             scl_s;
    logic [DIV_W-1:0] reload_val;
    bg_cmd_e          cmd;
    logic             step;
    logic             expire;

    i2c_bg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (scl_pin_i),
        .q_o (scl_s)
    );

    i2c_bg_div_norm #(.DIV_W(DIV_W)) u_norm (
        .divisor_i (divisor),
        .reload_o  (reload_val)
    );

    i2c_bg_cmd_dec u_cmd (
        .run_i     (run_i),
        .reload_i  (reload_i),
        .suspend_i (suspend_i),
        .cmd_o     (cmd)
    );

    assign step   = phase_a_en | phase_b_en;
    assign expire = (st_q.count <= LAST_STEP);

    always_comb begin
        st_d         = st_q;
        st_d.timeout = 1'b0;
        unique case (cmd)
            CMD_RELOAD: begin
                st_d.count = reload_val;
                st_d.susp  = 1'b0;
                st_d.hold  = 1'b0;
            end
            CMD_SUSPEND: st_d.susp = 1'b1;
            CMD_RUN:     st_d.susp = 1'b0;
            default: begin
                if (!st_q.susp && step) begin
                    if (st_q.hold) begin
                        // Waiting for another device to let SCL go high.
                        if (scl_s) begin
                            st_d.count   = reload_val;
                            st_d.hold    = 1'b0;
                            st_d.timeout = 1'b1;
                        end
                    end else if (!expire) begin
                        st_d.count = st_q.count - LAST_STEP;
                    end else if (scl_released_i && !scl_s) begin
                        st_d.count = '0;
                        st_d.hold  = 1'b1;
                    end else begin
                        st_d.count   = reload_val;
                        st_d.timeout = 1'b1;
                    end
                end
            end
        endcase
        if (rst) st_d = RESET_STATE;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign timeout_o = st_q.timeout;
    assign count_o   = st_q.count;
endmodule

// File: rtl/i2c_baud_gen_chk.sv
module i2c_baud_gen_chk #(
    parameter int DIV_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             phase_a_en,
    input logic             phase_b_en,
    input logic [DIV_W-1:0] divisor,
    input logic             reload_i,
    input logic             suspend_i,
    input logic             timeout_o,
    input logic [DIV_W-1:0] count_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count_o == '0 && !timeout_o)); // R1

    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> count_o == (($past(divisor) == '0) ? DIV_W'(1) : $past(divisor))); // R2

    AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!reload_i && !phase_a_en && !phase_b_en) |=> ($stable(count_o) && !timeout_o)); // R3

    AST_TIMEOUT_RELOADS: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> count_o == (($past(divisor) == '0) ? DIV_W'(1) : $past(divisor))); // R4

    AST_SUSPEND_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (suspend_i && !reload_i) |=> ($stable(count_o) && !timeout_o)); // R8
endmodule

bind i2c_baud_gen i2c_baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase_a_en (phase_a_en),
    .phase_b_en (phase_b_en),
    .divisor    (divisor),
    .reload_i   (reload_i),
    .suspend_i  (suspend_i),
    .timeout_o  (timeout_o),
    .count_o    (count_o)
);

// File: tb/i2c_baud_gen_bench.sv
module i2c_baud_gen_bench;
    localparam int DW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          phase_a_en = 1'b0;
    logic          phase_b_en = 1'b0;
    logic [DW-1:0] divisor = '0;
    logic          run_i = 1'b0;
    logic          reload_i = 1'b0;
    logic          suspend_i = 1'b0;
    logic          scl_released_i = 1'b0;
    logic          scl_pin_i = 1'b1;
    logic          timeout_o;
    logic [DW-1:0] count_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    i2c_baud_gen #(.DIV_W(DW), .SYNC_STAGES(2)) u_i2c_baud_gen (
        .clk            (clk),
        .rst            (rst),
        .phase_a_en     (phase_a_en),
        .phase_b_en     (phase_b_en),
        .divisor        (divisor),
        .run_i          (run_i),
        .reload_i       (reload_i),
        .suspend_i      (suspend_i),
        .scl_released_i (scl_released_i),
        .scl_pin_i      (scl_pin_i),
        .timeout_o      (timeout_o),
        .count_o        (count_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input bit on);
        phase_a_en = on;
        phase_b_en = 1'b0;
    endtask

    // Reload with d, then step once every p clocks and follow the count.
    task automatic sweep(input int d, input int p);
        int eff;
        eff = (d == 0) ? 1 : d;
        divisor  = DW'(d);
        reload_i = 1'b1;
        tick();
        reload_i = 1'b0;
        check(d == 0 ? "R5 reload zero" : "R2 reload", int'(count_o), eff);
        for (int n = 1; n <= eff * p; n++) begin
            phase_a_en = (n % p == 0) && (n % 2 == 1);
            phase_b_en = (n % p == 0) && (n % 2 == 0);
            tick();
            if (n < eff * p) begin
                check("R3 count", int'(count_o), eff - n / p);
                check("R3 no timeout", int'(timeout_o), 0);
            end else begin
                check(d == 0 ? "R5 timeout" : "R4 timeout", int'(timeout_o), 1);
                check("R4 reload count", int'(count_o), eff);
            end
        end
        phase_a_en = 1'b0;
        phase_b_en = 1'b0;
        tick();
        check("R10 single pulse", int'(timeout_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (3) tick();
        check("R1 reset count", int'(count_o), 0);
        check("R1 reset timeout", int'(timeout_o), 0);
        rst = 1'b0;
        steps(1'b1);
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            tick();
            seen += int'(timeout_o);
        end
        check("R1 suspended count", int'(count_o), 0);
        check("R1 suspended timeout", seen, 0);
        steps(1'b0);

        // Period sweep: divisor 0..9 and full scale, step spacing 1..3.
        for (int d = 0; d < 10; d++)
            for (int p = 1; p <= 3; p++)
                sweep(d, p);
        sweep(127, 1);

        // Hold-off: released SCL held low by another device.
        scl_released_i = 1'b1;
        scl_pin_i      = 1'b0;
        repeat (3) tick();
        divisor  = 7'd3;
        reload_i = 1'b1;
        tick();
        reload_i = 1'b0;
        check("R2 reload hold", int'(count_o), 3);
        steps(1'b1);
        tick();
        check("R3 hold count", int'(count_o), 2);
        tick();
        check("R3 hold count", int'(count_o), 1);
        tick();
        check("R6 expiry count", int'(count_o), 0);
        check("R6 expiry no timeout", int'(timeout_o), 0);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            seen += int'(timeout_o) + int'(count_o);
        end
        check("R6 stays held", seen, 0);
        scl_pin_i = 1'b1;
        tick();
        check("R9 first edge timeout", int'(timeout_o), 0);
        check("R9 first edge count", int'(count_o), 0);
        tick();
        check("R9 second edge timeout", int'(timeout_o), 0);
        check("R9 second edge count", int'(count_o), 0);
        tick();
        check("R7 release timeout", int'(timeout_o), 1);
        check("R7 release count", int'(count_o), 3);
        tick();
        check("R10 pulse ends", int'(timeout_o), 0);
        check("R7 counting resumes", int'(count_o), 2);
        steps(1'b0);
        scl_released_i = 1'b0;

        // Suspend and run.
        divisor  = 7'd6;
        reload_i = 1'b1;
        tick();
        reload_i = 1'b0;
        steps(1'b1);
        repeat (2) tick();
        check("R3 before suspend", int'(count_o), 4);
        suspend_i = 1'b1;
        tick();
        suspend_i = 1'b0;
        check("R8 suspend cycle", int'(count_o), 4);
        repeat (3) tick();
        check("R8 frozen under steps", int'(count_o), 4);
        steps(1'b0);
        run_i = 1'b1;
        tick();
        run_i = 1'b0;
        check("R8 run no reload", int'(count_o), 4);
        steps(1'b1);
        tick();
        check("R8 resumed", int'(count_o), 3);

        // Command priority.
        divisor   = 7'd5;
        reload_i  = 1'b1;
        suspend_i = 1'b1;
        tick();
        reload_i  = 1'b0;
        suspend_i = 1'b0;
        check("R10 reload wins", int'(count_o), 5);
        tick();
        check("R10 running after reload", int'(count_o), 4);
        run_i     = 1'b1;
        suspend_i = 1'b1;
        tick();
        run_i     = 1'b0;
        suspend_i = 1'b0;
        check("R10 suspend over run", int'(count_o), 4);
        tick();
        check("R10 suspend held", int'(count_o), 4);

        // Reset in mid-run.
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 mid reset", int'(count_o), 0);
        tick();
        check("R1 suspended after reset", int'(count_o), 0);
        steps(1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule